// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers interrupt requests from eight external request pins and from eight internal interrupt levels. Internal peripherals each present a request bit and an eight-bit one-hot field that chooses which of the eight levels they drive. All sixteen sources are combined into one live pending register. A software mask register gates them, and a fixed priority order picks a single winner among the unmasked pending sources.

The pins and levels share one interleaved priority order. The winner is reported as a byte offset into a table of 32-bit handler addresses, held in an eight-bit vector register. A single request line to the core is raised whenever any unmasked source is pending. A small synchronous register port lets software write the mask register and read the mask, pending and vector registers.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending register shows the current level of every request pin and every internal level, one clock edge after the inputs; there is no latching and no clear.
- R2: Priority positions interleave the sources: pin k takes position 2k and level k takes position 2k+1. Pin 0 is position 0 and level 7 is position 15.
- R3: In the mask and pending registers, bit 0 is the most significant bit, so position p sits in data bit 15-p; for example, mask bit 9 is data value 0x0040.
- R4: Each peripheral requests the level named in its one-hot field, with field bit 0 as the MSB, so level n is data bit 7-n and level 4 is 0x08. Several peripherals are ORed together, and a peripheral whose request bit is low has no effect.
- R5: A pending source is forwarded only when its mask bit is 1. The mask resets to all zero.
- R6: Among the pending, unmasked sources, the lowest-numbered position wins.
- R7: The vector code is four times the winning position. It reads at address 2, zero-extended to 16 bits.
- R8: When no unmasked source is pending, the core request line is low and the vector code is 64.
- R9: Address 0 reads pending, address 1 reads and writes the mask, address 2 reads the vector, and address 3 reads 0. Writes to addresses 0, 2 and 3 change nothing. Read data appears one edge after the read is issued.
- R10: After reset, pending, mask and read data are zero, the request line is low and the vector code is 64.
- R11: The request line and the vector code follow a change on the request inputs after two clock edges, and follow a mask write after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_i | input | 8 | External request pins, bit k = pin k, active high |
| periph_req_i | input | 4 | Request bit of each internal peripheral |
| periph_lvl_i | input | 32 | One-hot level fields, 8 bits per peripheral |
| reg_cs_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Request line to the core |

## Verification
The pending register takes its value at the first edge after an input change. The request line and the vector take theirs at the second edge, or at the first edge after a mask write. A read returns its data at the edge that accepts it. The bench changes inputs only on falling edges and holds them steady, waits exactly the required number of rising edges, and samples on the following falling edge. It also checks the request line in the gap between a mask write and the next edge, to confirm it has not yet changed.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        RA_PEND = 2'd0,
        RA_MASK = 2'd1,
        RA_VEC  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    localparam int unsigned CODE_STRIDE_LOG2 = 2;

endpackage

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
    parameter int unsigned N_PERIPH = 4,
    parameter int unsigned N_LEVELS = 8
) (
    input  logic [N_PERIPH-1:0]          periph_req_i,
    input  logic [N_PERIPH*N_LEVELS-1:0] periph_lvl_i,
    output logic [N_LEVELS-1:0]          level_o
);

    // level n is selected by field bit n counted from the MSB
    always_comb begin
        level_o = '0;
        for (int i = 0; i < N_PERIPH; i++) begin
            for (int n = 0; n < N_LEVELS; n++) begin
                if (periph_req_i[i] && periph_lvl_i[i*N_LEVELS + (N_LEVELS-1-n)]) begin
                    level_o[n] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_pend_map.sv
module irq_pend_map #(
    parameter int unsigned N_LEVELS = 8,
    localparam int unsigned N_POS   = 2 * N_LEVELS
) (
    input  logic [N_LEVELS-1:0] pins_i,
    input  logic [N_LEVELS-1:0] levels_i,
    output logic [N_POS-1:0]    pend_o
);

    // position 2k = pin k, 2k+1 = level k; position p lives in bit N_POS-1-p
    for (genvar k = 0; k < N_LEVELS; k++) begin : g_slot
        assign pend_o[N_POS-1-2*k] = pins_i[k];
        assign pend_o[N_POS-2-2*k] = levels_i[k];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N_POS = 16,
    parameter int unsigned VEC_W = 8
) (
    input  logic [N_POS-1:0] active_i,
    output logic             hit_o,
    output logic [VEC_W-1:0] code_o
);

    import irq_prio_pkg::*;

    // scan from the weakest position down so the lowest one is left standing
    always_comb begin
        hit_o  = 1'b0;
        code_o = VEC_W'(N_POS) << CODE_STRIDE_LOG2;
        for (int p = N_POS - 1; p >= 0; p--) begin
            if (active_i[N_POS-1-p]) begin
                hit_o  = 1'b1;
                code_o = VEC_W'(p) << CODE_STRIDE_LOG2;
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int unsigned N_LEVELS = 8,
    parameter int unsigned N_PERIPH = 4,
    parameter int unsigned VEC_W    = 8,
    localparam int unsigned N_POS   = 2 * N_LEVELS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_LEVELS-1:0]          ext_pin_i,
    input  logic [N_PERIPH-1:0]          periph_req_i,
    input  logic [N_PERIPH*N_LEVELS-1:0] periph_lvl_i,
    input  logic                         reg_cs_i,
    input  logic                         reg_we_i,
    input  logic [1:0]                   reg_addr_i,
    input  logic [N_POS-1:0]             reg_wdata_i,
    output logic [N_POS-1:0]             reg_rdata_o,
    output logic                         irq_o
);

    import irq_prio_pkg::*;

    localparam logic [VEC_W-1:0] IDLE_CODE = VEC_W'(N_POS) << CODE_STRIDE_LOG2;

    typedef struct packed {
        logic [N_POS-1:0] pend;
        logic [N_POS-1:0] mask;
        logic [VEC_W-1:0] vec;
        logic             irq;
        logic [N_POS-1:0] rdata;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic [N_LEVELS-1:0] level_w;
    logic [N_POS-1:0]    pend_raw_w;
    logic                hit_w;
    logic [VEC_W-1:0]    code_w;

    irq_level_merge #(.N_PERIPH(N_PERIPH), .N_LEVELS(N_LEVELS)) u_merge (
        .periph_req_i (periph_req_i),
        .periph_lvl_i (periph_lvl_i),
        .level_o      (level_w)
    );

    irq_pend_map #(.N_LEVELS(N_LEVELS)) u_map (
        .pins_i   (ext_pin_i),
        .levels_i (level_w),
        .pend_o   (pend_raw_w)
    );

    irq_prio_pick #(.N_POS(N_POS), .VEC_W(VEC_W)) u_pick (
        .active_i (s_q.pend & s_q.mask),
        .hit_o    (hit_w),
        .code_o   (code_w)
    );

    always_comb begin
        s_d      = s_q;
        s_d.pend = pend_raw_w;
        s_d.irq  = hit_w;
        s_d.vec  = code_w;
        if (reg_cs_i && reg_we_i && (reg_addr_e'(reg_addr_i) == RA_MASK)) begin
            s_d.mask = reg_wdata_i;
        end
        if (reg_cs_i && !reg_we_i) begin
            case (reg_addr_e'(reg_addr_i))
                RA_PEND: s_d.rdata = s_q.pend;
                RA_MASK: s_d.rdata = s_q.mask;
                RA_VEC:  s_d.rdata = N_POS'(s_q.vec);
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.vec   <= IDLE_CODE;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata_o = s_q.rdata;
    assign irq_o       = s_q.irq;

    logic [N_POS-1:0] pend_q, mask_q;
    logic [VEC_W-1:0] vec_q;
    assign pend_q = s_q.pend;
    assign mask_q = s_q.mask;
    assign vec_q  = s_q.vec;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int unsigned N_POS = 16,
    parameter int unsigned VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin0,
    input logic [N_POS-1:0] pend_q,
    input logic [N_POS-1:0] mask_q,
    input logic [VEC_W-1:0] vec_q,
    input logic             irq_o,
    input logic             reg_cs_i,
    input logic             reg_we_i,
    input logic [1:0]       reg_addr_i,
    input logic [N_POS-1:0] reg_wdata_i
);

    localparam logic [VEC_W-1:0] IDLE = VEC_W'(N_POS) << 2;

    p_pin0_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pin0 |=> pend_q[N_POS-1]);

    p_needs_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(pend_q & mask_q) != '0));

    p_follows_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q & mask_q) != '0) |-> irq_o);

    p_top_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pend_q[N_POS-1] & mask_q[N_POS-1]) |-> (vec_q == '0));

    p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_q == IDLE));

    p_code_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q[1:0] == 2'b00);

    p_mask_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cs_i && reg_we_i && reg_addr_i == 2'd1) |=> (mask_q == $past(reg_wdata_i)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_POS(N_POS), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin0        (ext_pin_i[0]),
    .pend_q      (pend_q),
    .mask_q      (mask_q),
    .vec_q       (vec_q),
    .irq_o       (irq_o),
    .reg_cs_i    (reg_cs_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_pin = '0;
    logic [3:0]  preq = '0;
    logic [31:0] plvl = '0;
    logic        cs = 1'b0, we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mask_m = '0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .periph_req_i(preq),
        .periph_lvl_i(plvl), .reg_cs_i(cs), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [7:0] m_levels(input logic [3:0] r, input logic [31:0] f);
        logic [7:0] l = '0;
        for (int i = 0; i < 4; i++)
            for (int n = 0; n < 8; n++)
                if (r[i] && f[i*8 + 7 - n]) l[n] = 1'b1;
        return l;
    endfunction

    function automatic logic [15:0] m_pend(input logic [7:0] p, input logic [7:0] l);
        logic [15:0] v = '0;
        for (int k = 0; k < 8; k++) begin
            v[15 - 2*k] = p[k];
            v[14 - 2*k] = l[k];
        end
        return v;
    endfunction

    function automatic logic [7:0] m_code(input logic [15:0] pend, input logic [15:0] msk);
        for (int p = 0; p < 16; p++)
            if (pend[15-p] && msk[15-p]) return 8'(p * 4);
        return 8'd64;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        @(negedge clk);
        cs = 1'b0;
        d = rdata;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        if (a == 2'd1) mask_m = d;
        @(posedge clk);
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    // drive inputs and wait the two edges until irq and vector follow
    task automatic apply(input logic [7:0] p, input logic [3:0] r, input logic [31:0] f);
        @(negedge clk);
        ext_pin = p; preq = r; plvl = f;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic verify(input string tag);
        logic [15:0] d;
        logic [15:0] ep;
        ep = m_pend(ext_pin, m_levels(preq, plvl));
        check({tag, " irq R5/R8"}, 32'(irq), 32'(m_code(ep, mask_m) != 8'd64));
        reg_read(2'd0, d);
        check({tag, " pending R1/R2/R3"}, 32'(d), 32'(ep));
        reg_read(2'd2, d);
        check({tag, " vector R6/R7"}, 32'(d), 32'(m_code(ep, mask_m)));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 irq in reset", 32'(irq), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 rdata after reset", 32'(rdata), 32'd0);
        reg_read(2'd1, d);  check("R10 mask reset", 32'(d), 32'd0);
        reg_read(2'd2, d);  check("R10 vector idle", 32'(d), 32'd64);
        reg_read(2'd0, d);  check("R10 pending reset", 32'(d), 32'd0);

        // pin 0 pending while everything masked
        apply(8'h01, 4'h0, 32'h0);
        check("R5 masked pin0 irq low", 32'(irq), 32'd0);
        reg_read(2'd0, d);  check("R1 R3 pin0 at bit15", 32'(d), 32'h8000);
        reg_read(2'd2, d);  check("R8 idle code", 32'(d), 32'd64);

        // R11: mask write takes effect one edge later
        reg_write(2'd1, 16'hFFFF);
        check("R11 irq unchanged right after write", 32'(irq), 32'd0);
        @(posedge clk); @(negedge clk);
        check("R11 irq one edge after mask write", 32'(irq), 32'd1);
        reg_read(2'd2, d);  check("R6 pin0 code", 32'(d), 32'd0);
        reg_read(2'd1, d);  check("R9 mask readback", 32'(d), 32'hFFFF);

        // R11: input change needs two edges
        @(negedge clk);
        ext_pin = 8'h00;
        @(posedge clk); @(negedge clk);
        check("R11 irq held one edge after input drop", 32'(irq), 32'd1);
        @(posedge clk); @(negedge clk);
        check("R11 irq low two edges after input drop", 32'(irq), 32'd0);

        // pin 0 and level 7 together: pin 0 wins (R6, R2)
        apply(8'h01, 4'h1, 32'h0000_0001);
        reg_read(2'd0, d);  check("R2 pin0+level7 pending", 32'(d), 32'h8001);
        reg_read(2'd2, d);  check("R6 pin0 beats level7", 32'(d), 32'd0);

        // level 4 via field 0x08 on peripheral 1, mask bit 9 only (R4, R3)
        reg_write(2'd1, 16'h0040);
        apply(8'h00, 4'h2, 32'h0000_0800);
        reg_read(2'd0, d);  check("R4 level4 at position 9", 32'(d), 32'h0040);
        reg_read(2'd2, d);  check("R7 level4 code 36", 32'(d), 32'd36);
        check("R5 level4 unmasked irq", 32'(irq), 32'd1);
        reg_write(2'd1, 16'hFFBF);
        @(posedge clk); @(negedge clk);
        check("R5 level4 masked irq low", 32'(irq), 32'd0);

        // request bit low: field ignored (R4)
        apply(8'h00, 4'h0, 32'hFFFF_FFFF);
        reg_read(2'd0, d);  check("R4 req low ignored", 32'(d), 32'h0000);

        // pin 7 vs level 7 (R6)
        reg_write(2'd1, 16'hFFFF);
        apply(8'h80, 4'h8, 32'h0100_0000);
        reg_read(2'd2, d);  check("R6 pin7 code 56", 32'(d), 32'd56);

        // ignored writes (R9)
        reg_write(2'd0, 16'h1234);
        reg_write(2'd2, 16'h0004);
        reg_write(2'd3, 16'h5555);
        reg_read(2'd0, d);  check("R9 pending write ignored", 32'(d), 32'h0003);
        reg_read(2'd2, d);  check("R9 vector write ignored", 32'(d), 32'd56);
        reg_read(2'd1, d);  check("R9 mask unchanged", 32'(d), 32'hFFFF);
        reg_read(2'd3, d);  check("R9 addr3 reads zero", 32'(d), 32'd0);

        // constrained random
        for (int it = 0; it < 300; it++) begin
            logic [7:0]  p;
            logic [3:0]  r;
            logic [31:0] f;
            p = 8'($urandom) & 8'($urandom);
            r = 4'($urandom);
            f = '0;
            for (int i = 0; i < 4; i++)
                if ($urandom % 4 != 0) f[i*8 +: 8] = 8'h01 << ($urandom % 8);
            if (it % 10 == 0) reg_write(2'd1, 16'($urandom));
            apply(p, r, f);
            verify("random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule